// File: doc/BRIEF.md
# Serial Clock and Parameter RAM Slave

This block is the far end of a three-wire serial link that a host drives with ordinary general-purpose port bits. The host lowers an active-low select line, then toggles a serial clock while it either drives the data line itself or releases it so that the slave can drive it back. Every exchange is built from 8-bit bytes sent most significant bit first. The first byte of a frame is a command. It can ask for a byte of a free-running 32-bit seconds counter, for a byte of a battery-style parameter RAM, or for a change to a write-protect flag.

The seconds counter advances once for every pulse on a 1 Hz strobe input. Its zero value stands for midnight at the start of 1 January 1904. The parameter RAM has 2^PRAM_AW bytes. It is reachable in two ways: a one-byte short form that covers its first four bytes, and a two-byte extended form in which a 3-bit sector taken from the command combines with a 5-bit address from the following byte. Writes are two bytes long, or three bytes in the extended form. While the write-protect flag is set, the block drops every write except a write to the protect register itself.

All port lines are synchronised into the system clock. Serial clock edges are found by comparing the synchronised clock with its previous value, so the host must hold each clock level for several system clock cycles.

Top module: `rtc_pram_slave`

## Requirements
- R1: After reset the slave drives sdo low, the seconds counter holds RESET_SECONDS (default 0), write protect is clear, and no command is pending.
- R2: While port_pins[2] (select, active low) is high, clock edges and data are ignored. Raising it discards a partly received byte, any pending command and any unsent read data, so the next frame begins with a fresh command byte.
- R3: While host_drives_data is 1, each rising edge of port_pins[1] shifts port_pins[0] in, most significant bit first. The eighth bit completes a byte.
- R4: While host_drives_data is 0 and read data is loaded, each falling edge of port_pins[1] puts the next bit, most significant first, on sdo. After eight bits, further falling edges leave sdo unchanged.
- R5: The read commands 0x81, 0x85, 0x89 and 0x8D return seconds byte 0 (least significant), 1, 2 and 3 respectively. The counter value used is the one present when the command byte completes.
- R6: The seconds counter adds one for each cycle in which sec_tick is 1. The write commands 0x01, 0x05, 0x09 and 0x0D, each followed by a data byte, replace byte 0, 1, 2 and 3 respectively.
- R7: The short read command 0xA1 | (k<<2) returns RAM byte k. The short write command 0x21 | (k<<2), followed by a data byte, stores that byte at k (k = 0..3). The short form and the extended form address the same array.
- R8: In the extended form the first byte is 0xB8 | s for a read or 0x38 | s for a write (s = sector). Bits 6:2 of the second byte hold the address a, and the other bits of that byte are ignored. The RAM index is (s*8 + a) truncated to PRAM_AW bits. A read returns that byte. A write stores the third byte there.
- R9: Writing command 0x35 with a data byte copies data bit 0 into write protect, and this write is always accepted. While write protect is 1, every other write completes its framing but changes nothing.
- R10: The write command 0x31 (test register) and command bytes that match no form listed above change nothing. A read command that matches no read form loads no data, so sdo stays constant through the falling edges that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle 1 Hz strobe that advances the seconds counter |
| port_pins | input | 3 | Host port lines: bit 2 select (active low), bit 1 serial clock, bit 0 host data |
| host_drives_data | input | 1 | 1 when the host drives the data line, 0 when it listens |
| sdo | output | 1 | Data bit driven back to the host |

## Verification
The hardest case to reach from the ports is the way the extended sector and address fields alias onto the RAM. Many (sector, address) pairs land on the same index, and a later write silently replaces an earlier one. The bench sweeps all 256 pairs through the three-byte write form, with the don't-care bits of the address byte set to 1. It then reads every pair back through the extended form and the shared low bytes through the short form, comparing each result with its own index arithmetic. Aborted frames are reached by deselecting after part of a byte, and after a write command that has no data byte yet.

// File: rtl/rtc_pram_pkg.sv
package rtc_pram_pkg;

  localparam int BYTE_W = 8;
  localparam int SEC_W  = 32;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SEC,
    OP_PRAM_SHORT,
    OP_EXT,
    OP_WPROT,
    OP_TEST
  } op_e;

  // Command class; bit 7 (direction) is not looked at here.
  function automatic op_e classify(input logic [7:0] c);
    op_e r;
    if (c[6:4] == 3'b000 && c[1:0] == 2'b01)       r = OP_SEC;
    else if ((c & 8'h73) == 8'h21)                 r = OP_PRAM_SHORT;
    else if ((c & 8'h78) == 8'h38)                 r = OP_EXT;
    else if (c[6:0] == 7'h35)                      r = OP_WPROT;
    else if (c[6:0] == 7'h31)                      r = OP_TEST;
    else                                           r = OP_NONE;
    return r;
  endfunction

  // Extended index before truncation to the RAM address width.
  function automatic logic [15:0] ext_index(input logic [2:0] sector,
                                            input logic [4:0] addr);
    return ({13'd0, sector} << 3) + {11'd0, addr};
  endfunction

  function automatic logic [15:0] short_index(input logic [1:0] k);
    return {14'd0, k};
  endfunction

  function automatic logic [7:0] sec_lane(input logic [SEC_W-1:0] s,
                                          input logic [1:0] lane);
    return s[8*lane +: 8];
  endfunction

  // Next counter value: tick first, then an optional byte replacement.
  function automatic logic [SEC_W-1:0] sec_advance(input logic [SEC_W-1:0] s,
                                                   input logic tick,
                                                   input logic wr,
                                                   input logic [1:0] lane,
                                                   input logic [7:0] val);
    logic [SEC_W-1:0] n;
    n = s + {{(SEC_W-1){1'b0}}, tick};
    if (wr) n[8*lane +: 8] = val;
    return n;
  endfunction

endpackage

// File: rtl/rtc_pin_sync.sv
module rtc_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pins,
  input  logic       host_drv,
  output logic       ce_act,
  output logic       sclk_rise,
  output logic       sclk_fall,
  output logic       sdi_q,
  output logic       host_drv_q
);
  localparam int LANE_W  = 4;
  localparam int CHAIN_W = SYNC_STAGES * LANE_W;
  localparam logic [LANE_W-1:0] IDLE_LANE = 4'b0100;

  logic [LANE_W-1:0]  raw;
  logic [CHAIN_W-1:0] chain;
  logic [LANE_W-1:0]  synced;
  logic               sclk_prev;

  assign raw = {host_drv, pins};

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= IDLE_LANE;
        else        chain <= raw;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {SYNC_STAGES{IDLE_LANE}};
        else        chain <= {chain[CHAIN_W-LANE_W-1:0], raw};
      end
    end
  endgenerate

  assign synced = chain[CHAIN_W-1 -: LANE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= synced[1];
  end

  assign ce_act     = ~synced[2];
  assign sdi_q      = synced[0];
  assign host_drv_q = synced[3];
  assign sclk_rise  = ce_act &  synced[1] & ~sclk_prev;
  assign sclk_fall  = ce_act & ~synced[1] &  sclk_prev;
endmodule

// File: rtl/rtc_shift_unit.sv
module rtc_shift_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_act,
  input  logic       sclk_rise,
  input  logic       sclk_fall,
  input  logic       host_drv,
  input  logic       sdi,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sdo,
  output logic [3:0] tx_left,
  output logic       tx_shift
);
  logic [6:0] rx_part;
  logic [2:0] rx_cnt;
  logic [7:0] tx_sh;
  logic       rx_shift;

  assign rx_shift = sclk_rise & host_drv;
  assign tx_shift = sclk_fall & ~host_drv & (tx_left != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_part   <= '0;
      rx_cnt    <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!ce_act) begin
        rx_cnt <= '0;
      end else if (rx_shift) begin
        if (rx_cnt == 3'd7) begin
          rx_byte   <= {rx_part, sdi};
          byte_done <= 1'b1;
          rx_cnt    <= '0;
        end else begin
          rx_part <= {rx_part[5:0], sdi};
          rx_cnt  <= rx_cnt + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_left <= '0;
      sdo     <= 1'b0;
    end else if (!ce_act) begin
      tx_left <= '0;
    end else if (tx_load) begin
      tx_sh   <= tx_byte;
      tx_left <= 4'd8;
    end else if (tx_shift) begin
      sdo     <= tx_sh[7];
      tx_sh   <= {tx_sh[6:0], 1'b0};
      tx_left <= tx_left - 4'd1;
    end
  end
endmodule

// File: rtl/rtc_cmd_engine.sv
module rtc_cmd_engine
  import rtc_pram_pkg::*;
#(
  parameter int          PRAM_AW       = 8,
  parameter logic [31:0] RESET_SECONDS = 32'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_act,
  input  logic             sec_tick,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  output logic             tx_load,
  output logic [7:0]       tx_byte,
  output logic             wr_blocked,
  output logic             sec_wr,
  output logic             wp_flag,
  output logic [SEC_W-1:0] seconds
);
  localparam int DEPTH = 1 << PRAM_AW;

  logic             pend_vld, pend_vld_n;
  logic [7:0]       pend_cmd, pend_cmd_n;
  logic             addr_vld, addr_vld_n;
  logic [4:0]       ext_addr, ext_addr_n;
  logic             wp_n;
  logic [7:0]       pram [DEPTH];
  logic             ram_we;
  logic [15:0]      widx_full, ridx_full;
  logic [PRAM_AW-1:0] ram_widx, ram_ridx;
  logic [7:0]       ram_rdata;
  logic [1:0]       lane;
  logic [7:0]       lane_val;
  op_e              op_new, op_pend;

  assign op_new  = classify(rx_byte);
  assign op_pend = classify(pend_cmd);

  // Read index: extended when a read is pending, short otherwise.
  assign ridx_full = (pend_vld && pend_cmd[7]) ? ext_index(pend_cmd[2:0], rx_byte[6:2])
                                               : short_index(rx_byte[3:2]);
  assign widx_full = (op_pend == OP_EXT) ? ext_index(pend_cmd[2:0], ext_addr)
                                         : short_index(pend_cmd[3:2]);
  assign ram_ridx  = ridx_full[PRAM_AW-1:0];
  assign ram_widx  = widx_full[PRAM_AW-1:0];
  assign ram_rdata = pram[ram_ridx];

  always_comb begin
    pend_vld_n = pend_vld;
    pend_cmd_n = pend_cmd;
    addr_vld_n = addr_vld;
    ext_addr_n = ext_addr;
    wp_n       = wp_flag;
    tx_load    = 1'b0;
    tx_byte    = '0;
    wr_blocked = 1'b0;
    sec_wr     = 1'b0;
    lane       = pend_cmd[3:2];
    lane_val   = rx_byte;
    ram_we     = 1'b0;
    if (!ce_act) begin
      pend_vld_n = 1'b0;
      addr_vld_n = 1'b0;
    end else if (byte_done) begin
      if (!pend_vld) begin
        if (rx_byte[7]) begin
          case (op_new)
            OP_SEC: begin
              tx_load = 1'b1;
              tx_byte = sec_lane(seconds, rx_byte[3:2]);
            end
            OP_PRAM_SHORT: begin
              tx_load = 1'b1;
              tx_byte = ram_rdata;
            end
            OP_EXT: begin
              pend_vld_n = 1'b1;
              pend_cmd_n = rx_byte;
            end
            default: ;
          endcase
        end else begin
          pend_vld_n = 1'b1;
          pend_cmd_n = rx_byte;
          addr_vld_n = 1'b0;
        end
      end else if (pend_cmd[7]) begin
        tx_load    = 1'b1;
        tx_byte    = ram_rdata;
        pend_vld_n = 1'b0;
      end else if (op_pend == OP_EXT && !addr_vld) begin
        addr_vld_n = 1'b1;
        ext_addr_n = rx_byte[6:2];
      end else begin
        pend_vld_n = 1'b0;
        addr_vld_n = 1'b0;
        if (wp_flag && op_pend != OP_WPROT) begin
          wr_blocked = 1'b1;
        end else begin
          case (op_pend)
            OP_SEC:        sec_wr = 1'b1;
            OP_PRAM_SHORT: ram_we = 1'b1;
            OP_EXT:        ram_we = 1'b1;
            OP_WPROT:      wp_n   = rx_byte[0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_cmd <= '0;
      addr_vld <= 1'b0;
      ext_addr <= '0;
      wp_flag  <= 1'b0;
      seconds  <= RESET_SECONDS;
    end else begin
      pend_vld <= pend_vld_n;
      pend_cmd <= pend_cmd_n;
      addr_vld <= addr_vld_n;
      ext_addr <= ext_addr_n;
      wp_flag  <= wp_n;
      seconds  <= sec_advance(seconds, sec_tick, sec_wr, lane, lane_val);
    end
  end

  always_ff @(posedge clk) begin
    if (ram_we) pram[ram_widx] <= rx_byte;
  end
endmodule

// File: rtl/rtc_pram_slave.sv
module rtc_pram_slave
  import rtc_pram_pkg::*;
#(
  parameter int          PRAM_AW       = 8,
  parameter int          SYNC_STAGES   = 2,
  parameter logic [31:0] RESET_SECONDS = 32'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] port_pins,
  input  logic       host_drives_data,
  output logic       sdo
);
  logic             ce_act;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             sdi_q;
  logic             host_drv_q;
  logic             byte_done;
  logic [7:0]       rx_byte;
  logic             tx_load;
  logic [7:0]       tx_byte;
  logic [3:0]       tx_left;
  logic             tx_shift;
  logic             wr_blocked;
  logic             sec_wr;
  logic             wp_flag;
  logic [SEC_W-1:0] seconds;

  rtc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins       (port_pins),
    .host_drv   (host_drives_data),
    .ce_act     (ce_act),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sdi_q      (sdi_q),
    .host_drv_q (host_drv_q)
  );

  rtc_shift_unit u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_act    (ce_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .host_drv  (host_drv_q),
    .sdi       (sdi_q),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .sdo       (sdo),
    .tx_left   (tx_left),
    .tx_shift  (tx_shift)
  );

  rtc_cmd_engine #(
    .PRAM_AW       (PRAM_AW),
    .RESET_SECONDS (RESET_SECONDS)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_act     (ce_act),
    .sec_tick   (sec_tick),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .tx_load    (tx_load),
    .tx_byte    (tx_byte),
    .wr_blocked (wr_blocked),
    .sec_wr     (sec_wr),
    .wp_flag    (wp_flag),
    .seconds    (seconds)
  );
endmodule

// File: rtl/rtc_pram_checker.sv
module rtc_pram_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sec_tick,
  input logic        sdo,
  input logic        ce_act,
  input logic        byte_done,
  input logic        tx_load,
  input logic        tx_shift,
  input logic [3:0]  tx_left,
  input logic        wr_blocked,
  input logic        wp_flag,
  input logic        sec_wr,
  input logic [31:0] seconds
);
  AST_NO_BYTE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ce_act) |-> !byte_done); // R2
  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done); // R3
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_shift |=> $stable(sdo)); // R4
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_left <= 4'd8); // R4
  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_shift && !tx_load && ce_act) |=> tx_left == $past(tx_left) - 4'd1); // R4
  AST_WP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> wp_flag); // R9
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !sec_wr) |=> seconds == $past(seconds) + 32'd1); // R6
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !sec_wr) |=> $stable(seconds)); // R6
endmodule

bind rtc_pram_slave rtc_pram_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .sdo        (sdo),
  .ce_act     (ce_act),
  .byte_done  (byte_done),
  .tx_load    (tx_load),
  .tx_shift   (tx_shift),
  .tx_left    (tx_left),
  .wr_blocked (wr_blocked),
  .wp_flag    (wp_flag),
  .sec_wr     (sec_wr),
  .seconds    (seconds)
);

// File: tb/sim_rtc_pram_slave.sv
`timescale 1ns/1ps
module sim_rtc_pram_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       ce_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       host_drv = 1'b1;
  logic       sdo;
  int         total = 0;
  int         failed = 0;
  bit         finished = 1'b0;
  logic [7:0] mem [256];
  logic [31:0] sec_model = 32'd0;

  always #5 clk = ~clk;

  rtc_pram_slave u0 (
    .clk              (clk),
    .rst_n            (rst_n),
    .sec_tick         (sec_tick),
    .port_pins        ({ce_n, sclk, sdi}),
    .host_drives_data (host_drv),
    .sdo              (sdo)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    host_drv = 1'b1;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i]; sclk = 1'b0; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    host_drv = 1'b0; wait_clk(2);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; wait_clk(4);
      b[i] = sdo;
      sclk = 1'b1; wait_clk(4);
    end
  endtask

  task automatic open_frame();
    sclk = 1'b0; ce_n = 1'b0; wait_clk(4);
  endtask

  task automatic close_frame();
    ce_n = 1'b1; sclk = 1'b0; host_drv = 1'b1; wait_clk(4);
  endtask

  task automatic rd_cmd(input logic [7:0] cmd, output logic [7:0] d);
    open_frame(); send_byte(cmd); recv_byte(d); close_frame();
  endtask

  task automatic wr_cmd(input logic [7:0] cmd, input logic [7:0] d);
    open_frame(); send_byte(cmd); send_byte(d); close_frame();
  endtask

  task automatic rd_ext(input int s, input int a, output logic [7:0] d);
    open_frame();
    send_byte(8'hB8 | 8'(s));
    send_byte({1'b1, 5'(a), 2'b11});
    recv_byte(d);
    close_frame();
  endtask

  task automatic wr_ext(input int s, input int a, input logic [7:0] d);
    open_frame();
    send_byte(8'h38 | 8'(s));
    send_byte({1'b1, 5'(a), 2'b11});
    send_byte(d);
    close_frame();
  endtask

  task automatic tick();
    sec_tick = 1'b1; wait_clk(1); sec_tick = 1'b0; wait_clk(1);
    sec_model = sec_model + 32'd1;
  endtask

  task automatic check_seconds(input string req);
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      rd_cmd(8'h81 | 8'(k << 2), d);
      check(req, {24'd0, d}, {24'd0, sec_model[8*k +: 8]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic       s0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    // R1: reset state
    check("R1 sdo after reset", {31'd0, sdo}, 32'd0);
    check_seconds("R1 R5 seconds after reset");

    // R6 R5: byte loads and ticks with carry
    wr_cmd(8'h01, 8'h11); wr_cmd(8'h05, 8'h22); wr_cmd(8'h09, 8'h33); wr_cmd(8'h0D, 8'h44);
    sec_model = 32'h44332211;
    check_seconds("R6 R5 seconds byte writes");
    tick(); tick(); tick();
    check_seconds("R6 tick count");
    wr_cmd(8'h01, 8'hFF); wr_cmd(8'h05, 8'h12);
    sec_model[15:0] = 16'h12FF;
    tick();
    check_seconds("R6 carry across bytes");

    // R7: short form
    for (int k = 0; k < 4; k++) begin
      wr_cmd(8'h21 | 8'(k << 2), 8'hC0 + 8'(k));
      mem[k] = 8'hC0 + 8'(k);
    end
    for (int k = 0; k < 4; k++) begin
      rd_cmd(8'hA1 | 8'(k << 2), d);
      check("R7 short read", {24'd0, d}, {24'd0, mem[k]});
    end

    // R8: exhaustive sector/address sweep with aliasing
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 32; a++) begin
        d = 8'(s * 29 + a * 7 + 3);
        wr_ext(s, a, d);
        mem[(s * 8 + a) & 255] = d;
      end
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 32; a++) begin
        rd_ext(s, a, d);
        check("R8 extended read", {24'd0, d}, {24'd0, mem[(s * 8 + a) & 255]});
      end
    for (int k = 0; k < 4; k++) begin
      rd_cmd(8'hA1 | 8'(k << 2), d);
      check("R7 short shares array", {24'd0, d}, {24'd0, mem[k]});
    end

    // R9: write protect
    wr_cmd(8'h35, 8'hFF);
    wr_cmd(8'h21, 8'h5A);
    rd_cmd(8'hA1, d);
    check("R9 protected short write", {24'd0, d}, {24'd0, mem[0]});
    wr_cmd(8'h0D, 8'h99);
    check_seconds("R9 protected seconds write");
    wr_ext(7, 31, 8'h66);
    rd_ext(7, 31, d);
    check("R9 protected extended write", {24'd0, d}, {24'd0, mem[87]});
    wr_cmd(8'h35, 8'hFE);
    wr_cmd(8'h21, 8'h5A);
    mem[0] = 8'h5A;
    rd_cmd(8'hA1, d);
    check("R9 unprotected write", {24'd0, d}, {24'd0, mem[0]});

    // R2: partial byte then deselect
    open_frame(); send_bits(8'hFF, 5); close_frame();
    rd_cmd(8'hA5, d);
    check("R2 partial byte dropped", {24'd0, d}, {24'd0, mem[1]});
    // R2: pending write dropped by deselect
    open_frame(); send_byte(8'h21); close_frame();
    rd_cmd(8'hA5, d);
    check("R2 pending cleared read", {24'd0, d}, {24'd0, mem[1]});
    rd_cmd(8'hA1, d);
    check("R2 pending cleared no write", {24'd0, d}, {24'd0, mem[0]});
    // R2: activity while deselected
    s0 = sdo;
    host_drv = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sdi = i[0]; sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    check("R2 sdo idle when deselected", {31'd0, sdo}, {31'd0, s0});
    rd_cmd(8'hA9, d);
    check("R2 frame after idle toggling", {24'd0, d}, {24'd0, mem[2]});

    // R4: trailing falls keep sdo
    mem[3] = 8'hA6;
    wr_cmd(8'h2D, 8'hA6);
    open_frame(); send_byte(8'hAD); recv_byte(d);
    check("R4 msb-first transmit", {24'd0, d}, 32'hA6);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; wait_clk(4);
      check("R4 sdo held after eight bits", {31'd0, sdo}, 32'd0);
      sclk = 1'b1; wait_clk(4);
    end
    close_frame();

    // R10: test register, unknown write, unknown read
    wr_cmd(8'h31, 8'h77);
    wr_cmd(8'h7F, 8'h77);
    rd_cmd(8'hA1, d);
    check("R10 test write no effect ram", {24'd0, d}, {24'd0, mem[0]});
    check_seconds("R10 test write no effect seconds");
    s0 = sdo;
    rd_cmd(8'h99, d);
    check("R10 unknown read no data", {24'd0, d}, {24'd0, {8{s0}}});

    summary();
  end
endmodule